// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block produces the timing of programmed-I/O read and write cycles on a two-drive IDE channel, measured in host bus clocks. A cycle request names one of the two drives and a direction. The block then runs three phases: address setup, active strobe and recovery. It raises busy for the whole cycle and pulses done once the cycle is over.

Timing comes from a small set of configuration bytes written through a simple write port. There are two timing sets, and each holds one byte for reads and one byte for writes. In each byte, the high nibble gives the strobe width as clocks minus one, and the low nibble gives the recovery length as clocks minus two. A shared byte holds the address setup time, a device-ready timing field and a read-prefetch enable. Address setup applies to both drives, so software loads the larger of the two drives' needs. A control byte chooses the timing set used by each drive. The device-ready and prefetch fields are only exposed at the ports, for use by neighbouring logic.

Top module: `pio_cycle_gen`

## Requirements
- R1: After reset, busy, done and every phase output are low, prefetch_en is 0 and drdy_clks is 2. Both drives use set A, both sets hold 0xFF, and address setup is 4 clocks, so the first cycle runs 4 setup, 16 strobe and 17 recovery clocks.
- R2: The strobe lasts (timing byte bits 7:4) + 1 clocks, from 1 to 16.
- R3: Recovery lasts (timing byte bits 3:0) + 2 clocks, from 2 to 17.
- R4: Address setup lasts (shared byte bits 5:4) + 1 clocks, from 1 to 4. The same value applies to both drives and in both directions.
- R5: Read cycles take their timing from the read byte of the selected set and assert strobe_rd. Write cycles take it from the write byte and assert strobe_wr.
- R6: Configuration addresses are: 0 set A read, 1 set A write, 2 set B read, 3 set B write, 4 shared byte, 5 control. In the control byte, bit 1 picks the set for drive 0 and bit 2 picks the set for drive 1, with 0 meaning A and 1 meaning B. The value 0x85 therefore maps drive 0 to A and drive 1 to B.
- R7: prefetch_en follows bit 6 of the shared byte, and drdy_clks equals (shared byte bits 2:1) + 2. Neither field changes the cycle timing.
- R8: Phases run in the order setup, strobe, recovery, with at most one phase output high at a time. busy is high exactly while a phase is active. done is high for one clock, the clock right after the last recovery clock, and busy is low in that clock.
- R9: A request is taken only while busy is low. A request made while busy is high is dropped, and no cycle follows it.
- R10: The timing of a cycle is captured when its request is taken. Configuration writes made during a cycle do not change that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration byte select |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 1 | Cycle request |
| req_drive | input | 1 | Drive addressed by the request |
| req_write | input | 1 | 1 for a write cycle, 0 for a read |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse after recovery ends |
| phase_setup | output | 1 | Address setup phase |
| strobe_rd | output | 1 | Read strobe active |
| strobe_wr | output | 1 | Write strobe active |
| phase_recov | output | 1 | Recovery phase |
| prefetch_en | output | 1 | Read-prefetch enable field |
| drdy_clks | output | 3 | Device-ready timing in clocks |

## Verification
The assertions assume that the inputs are known after reset and that reset is held for at least one clock. They also assume that a request changes the phase outputs only on the clock after it is taken. The prefetch check assumes the shared byte changes only through a write strobe. The stimulus drives every input at the falling edge and holds cfg_we for exactly one rising edge. It raises requests while busy only to exercise the drop rule. It writes configuration during a cycle only to show that the captured timing holds.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int BYTE_W    = 8;
  localparam int NIB_W     = 4;
  localparam int SETUP_W   = 2;
  localparam int DRDY_W    = 2;
  localparam int NUM_SETS  = 2;
  localparam int ADDR_W    = 3;
  localparam int NUM_TB    = NUM_SETS * 2;
  localparam int MAX_LEN   = 17;
  localparam int CNT_W     = $clog2(MAX_LEN + 1);
  localparam int MAX_SETUP = 1 << SETUP_W;

  localparam int ACT_OFS   = 1;
  localparam int REC_OFS   = 2;
  localparam int SETUP_OFS = 1;
  localparam int DRDY_OFS  = 2;

  localparam int MISC_ADDR = NUM_TB;
  localparam int CTRL_ADDR = NUM_TB + 1;

  localparam int PF_BIT     = 6;
  localparam int SETUP_LSB  = 4;
  localparam int DRDY_LSB   = 1;
  localparam int MAP_D0_BIT = 1;
  localparam int MAP_D1_BIT = 2;

  localparam logic [BYTE_W-1:0] TIMING_RST = '1;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_RECOV
  } phase_e;
endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
  import pio_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W,
  parameter int NT = NUM_TB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [BW-1:0]     wdata,
  output logic [NT*BW-1:0]  timing_o,
  output logic [SETUP_W-1:0] setup_code_o,
  output logic [DRDY_W-1:0] drdy_code_o,
  output logic              pf_o,
  output logic [1:0]        map_o
);
  // one register per timing byte: set-major, direction-minor
  for (genvar g = 0; g < NT; g++) begin : g_tb
    logic [BW-1:0] tb_q;
    always_ff @(posedge clk) begin
      if (rst) tb_q <= TIMING_RST;
      else if (we && addr == AW'(g)) tb_q <= wdata;
    end
    assign timing_o[g*BW +: BW] = tb_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_code_o <= '1;
      drdy_code_o  <= '0;
      pf_o         <= 1'b0;
    end else if (we && addr == AW'(MISC_ADDR)) begin
      setup_code_o <= wdata[SETUP_LSB +: SETUP_W];
      drdy_code_o  <= wdata[DRDY_LSB +: DRDY_W];
      pf_o         <= wdata[PF_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) map_o <= '0;
    else if (we && addr == AW'(CTRL_ADDR))
      map_o <= {wdata[MAP_D1_BIT], wdata[MAP_D0_BIT]};
  end
endmodule

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
  import pio_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int NT = NUM_TB,
  parameter int CW = CNT_W
) (
  input  logic [NT*BW-1:0]   timing_i,
  input  logic [SETUP_W-1:0] setup_code_i,
  input  logic [1:0]         map_i,
  input  logic               drive_i,
  input  logic               write_i,
  output logic [CW-1:0]      setup_clks,
  output logic [CW-1:0]      act_clks,
  output logic [CW-1:0]      rec_clks
);
  localparam int IDX_W = $clog2(NT);

  logic             set_sel;
  logic [IDX_W-1:0] idx;
  logic [BW-1:0]    tbyte;

  always_comb begin
    set_sel    = map_i[drive_i];
    idx        = IDX_W'({set_sel, write_i});
    tbyte      = timing_i[int'(idx)*BW +: BW];
    act_clks   = CW'(tbyte[BW-1:NIB_W]) + CW'(ACT_OFS);
    rec_clks   = CW'(tbyte[NIB_W-1:0]) + CW'(REC_OFS);
    setup_clks = CW'(setup_code_i) + CW'(SETUP_OFS);
  end
endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [CW-1:0] setup_clks,
  input  logic [CW-1:0] act_clks,
  input  logic [CW-1:0] rec_clks,
  output logic          phase_setup,
  output logic          strobe_rd,
  output logic          strobe_wr,
  output logic          phase_recov,
  output logic          busy,
  output logic          done
);
  phase_e        state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] act_q, rec_q;
  logic          wr_q;
  logic          accept;
  logic          last;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    accept  = 1'b0;
    last    = (cnt_q == '0);
    unique case (state_q)
      PH_IDLE: if (req_valid) begin
        state_n = PH_SETUP;
        cnt_n   = setup_clks - CW'(1);
        accept  = 1'b1;
      end
      PH_SETUP: if (last) begin
        state_n = PH_ACTIVE;
        cnt_n   = act_q - CW'(1);
      end else cnt_n = cnt_q - CW'(1);
      PH_ACTIVE: if (last) begin
        state_n = PH_RECOV;
        cnt_n   = rec_q - CW'(1);
      end else cnt_n = cnt_q - CW'(1);
      PH_RECOV: if (last) state_n = PH_IDLE;
        else cnt_n = cnt_q - CW'(1);
      default: state_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PH_IDLE;
      cnt_q       <= '0;
      act_q       <= '0;
      rec_q       <= '0;
      wr_q        <= 1'b0;
      phase_setup <= 1'b0;
      strobe_rd   <= 1'b0;
      strobe_wr   <= 1'b0;
      phase_recov <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      if (accept) begin
        act_q <= act_clks;
        rec_q <= rec_clks;
        wr_q  <= req_write;
      end
      phase_setup <= (state_n == PH_SETUP);
      strobe_rd   <= (state_n == PH_ACTIVE) && !wr_q;
      strobe_wr   <= (state_n == PH_ACTIVE) && wr_q;
      phase_recov <= (state_n == PH_RECOV);
      busy        <= (state_n != PH_IDLE);
      done        <= (state_q == PH_RECOV) && last;
    end
  end
endmodule

// File: rtl/pio_cycle_gen.sv
module pio_cycle_gen
  import pio_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [BW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic          req_drive,
  input  logic          req_write,
  output logic          busy,
  output logic          done,
  output logic          phase_setup,
  output logic          strobe_rd,
  output logic          strobe_wr,
  output logic          phase_recov,
  output logic          prefetch_en,
  output logic [2:0]    drdy_clks
);
  logic [NUM_TB*BW-1:0] timing;
  logic [SETUP_W-1:0]   setup_code;
  logic [DRDY_W-1:0]    drdy_code;
  logic [1:0]           map;
  logic [CNT_W-1:0]     setup_clks, act_clks, rec_clks;

  pio_cfg_regs #(.BW(BW), .AW(AW), .NT(NUM_TB)) i_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .timing_o(timing), .setup_code_o(setup_code), .drdy_code_o(drdy_code),
    .pf_o(prefetch_en), .map_o(map)
  );

  pio_timing_sel #(.BW(BW), .NT(NUM_TB), .CW(CNT_W)) i_sel (
    .timing_i(timing), .setup_code_i(setup_code), .map_i(map),
    .drive_i(req_drive), .write_i(req_write),
    .setup_clks(setup_clks), .act_clks(act_clks), .rec_clks(rec_clks)
  );

  pio_seq #(.CW(CNT_W)) i_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .setup_clks(setup_clks), .act_clks(act_clks), .rec_clks(rec_clks),
    .phase_setup(phase_setup), .strobe_rd(strobe_rd), .strobe_wr(strobe_wr),
    .phase_recov(phase_recov), .busy(busy), .done(done)
  );

  assign drdy_clks = 3'(drdy_code) + 3'(DRDY_OFS);
endmodule

// File: rtl/pio_cycle_gen_chk.sv
module pio_cycle_gen_chk
  import pio_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic cfg_we,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic phase_setup,
  input logic strobe_rd,
  input logic strobe_wr,
  input logic phase_recov,
  input logic prefetch_en
);
  logic [2:0] setup_run;
  always_ff @(posedge clk) begin
    if (rst) setup_run <= '0;
    else if (phase_setup) setup_run <= setup_run + 3'd1;
    else setup_run <= '0;
  end

  // R8
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({phase_setup, strobe_rd, strobe_wr, phase_recov}));
  // R8
  busy_phase_chk: assert property (@(posedge clk) disable iff (rst)
    busy == (phase_setup | strobe_rd | strobe_wr | phase_recov));
  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(phase_recov)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_setup) |-> $past(req_valid && !busy));
  // R2
  strobe_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(strobe_rd) || $rose(strobe_wr)) |-> $past(phase_setup));
  // R3
  recov_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_recov) |=> phase_recov);
  // R4
  setup_len_chk: assert property (@(posedge clk) disable iff (rst)
    phase_setup |-> (int'(setup_run) < MAX_SETUP));
  // R7
  pf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_we) |-> $stable(prefetch_en));
endmodule

bind pio_cycle_gen pio_cycle_gen_chk i_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .req_valid(req_valid),
  .busy(busy), .done(done), .phase_setup(phase_setup),
  .strobe_rd(strobe_rd), .strobe_wr(strobe_wr),
  .phase_recov(phase_recov), .prefetch_en(prefetch_en)
);

// File: tb/test_pio_cycle_gen.sv
module test_pio_cycle_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       req_valid = 1'b0, req_drive = 1'b0, req_write = 1'b0;
  logic       busy, done, phase_setup, strobe_rd, strobe_wr, phase_recov, prefetch_en;
  logic [2:0] drdy_clks;
  int vectors = 0, fails = 0;

  always #10 clk = ~clk;

  pio_cycle_gen i_pio_cycle_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_drive(req_drive), .req_write(req_write),
    .busy(busy), .done(done), .phase_setup(phase_setup), .strobe_rd(strobe_rd),
    .strobe_wr(strobe_wr), .phase_recov(phase_recov), .prefetch_en(prefetch_en),
    .drdy_clks(drdy_clks)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // mode 0 plain, 1 config writes mid-cycle (R10), 2 extra request while busy (R9)
  task automatic do_cycle(input bit drv, input bit wr, input int es, input int ea,
                          input int er, input string pfx, input int mode);
    int ns = 0, na = 0, nr = 0;
    bit bad_order = 0, bad_type = 0, seen_done = 0;
    @(negedge clk);
    req_valid = 1'b1; req_drive = drv; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 80 && !seen_done; k++) begin
      if (mode == 1) begin
        if (k == 0) begin cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'h00; end
        if (k == 1) begin cfg_addr = 3'd4; cfg_wdata = 8'h00; end
        if (k == 2) cfg_we = 1'b0;
      end
      if (mode == 2) begin
        if (k == 1) begin req_valid = 1'b1; req_drive = !drv; req_write = !wr; end
        if (k == 2) req_valid = 1'b0;
      end
      if (done) seen_done = 1;
      else begin
        if (phase_setup) begin ns++; if (na > 0 || nr > 0) bad_order = 1; end
        if (strobe_rd || strobe_wr) begin
          na++; if (nr > 0) bad_order = 1;
          if (strobe_rd == wr || strobe_wr != wr) bad_type = 1;
        end
        if (phase_recov) nr++;
        @(negedge clk);
      end
    end
    chk(ns == es, {pfx, " R4 setup clocks"}, ns, es);
    chk(na == ea, {pfx, " R2 strobe clocks"}, na, ea);
    chk(nr == er, {pfx, " R3 recovery clocks"}, nr, er);
    chk(!bad_type, {pfx, " R5 strobe direction"}, int'(bad_type), 0);
    chk(seen_done && !busy && !bad_order, {pfx, " R8 order and done"},
        int'({seen_done, busy, bad_order}), 4);
    if (mode == 2) begin
      @(negedge clk);
      chk(!busy && !phase_setup, {pfx, " R9 dropped request"}, int'(busy), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; vectors++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] tv [4];
    logic [7:0] ctl [4];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 busy/done after reset", int'({busy, done}), 0);
    chk(!phase_setup && !strobe_rd && !strobe_wr && !phase_recov, "R1 phases after reset",
        int'({phase_setup, strobe_rd, strobe_wr, phase_recov}), 0);
    chk(!prefetch_en && drdy_clks == 3'd2, "R1 shared fields after reset",
        int'({prefetch_en, drdy_clks}), 2);
    do_cycle(1'b0, 1'b0, 4, 16, 17, "R1 reset read d0", 0);
    do_cycle(1'b1, 1'b1, 4, 16, 17, "R1 reset write d1", 0);

    // exhaustive timing byte sweep on set A read
    for (int b = 0; b < 256; b++) begin
      wr_cfg(0, b);
      wr_cfg(4, (b % 4) << 4);
      do_cycle(1'b0, 1'b0, (b % 4) + 1, (b >> 4) + 1, (b % 16) + 2, "R2 R3 sweep", 0);
    end

    // R6 set mapping and R5 byte per direction
    tv[0] = 8'h12; tv[1] = 8'h34; tv[2] = 8'h56; tv[3] = 8'h78;
    for (int i = 0; i < 4; i++) wr_cfg(i, tv[i]);
    wr_cfg(4, 8'h10);
    ctl[0] = 8'h00; ctl[1] = 8'h02; ctl[2] = 8'h85; ctl[3] = 8'h06;
    for (int c = 0; c < 4; c++) begin
      wr_cfg(5, ctl[c]);
      for (int d = 0; d < 2; d++)
        for (int w = 0; w < 2; w++) begin
          int st;
          int by;
          st = (d == 1) ? int'(ctl[c][2]) : int'(ctl[c][1]);
          by = int'(tv[st * 2 + w]);
          do_cycle(d[0], w[0], 2, (by >> 4) + 1, (by % 16) + 2, "R6 R5 mapping", 0);
        end
    end

    // R7 shared byte fields
    for (int m = 0; m < 8; m++) begin
      wr_cfg(4, ((m >> 2) << 6) | (3 << 4) | ((m % 4) << 1));
      @(negedge clk);
      chk(prefetch_en == m[2], "R7 prefetch enable", int'(prefetch_en), m >> 2);
      chk(int'(drdy_clks) == (m % 4) + 2, "R7 drdy clocks", int'(drdy_clks), (m % 4) + 2);
    end
    wr_cfg(5, 8'h85);
    do_cycle(1'b1, 1'b1, 4, 8, 10, "R7 fields leave timing", 0);

    // R9 request while busy is dropped
    do_cycle(1'b0, 1'b1, 4, 4, 6, "R9 busy request", 2);

    // R10 mid-cycle config writes do not alter the running cycle
    do_cycle(1'b0, 1'b0, 4, 2, 4, "R10 mid-cycle write", 1);
    do_cycle(1'b0, 1'b0, 1, 1, 2, "R10 new values next cycle", 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule